// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Engine

This block turns plain bus reads into single-bit SPI flash read transactions. Each attached flash chip owns an address window on the bus. The window is described by a per-chip segment word that holds a start and an end, both counted in 8 MB units. When a read lands inside an open window, the engine picks that chip's select line. It then shifts out the chip's read opcode, the flash address, and any dummy bytes. Last, it clocks in four data bytes and returns them as one 32-bit word.

The flash address is the bus address minus the window start. The per-chip control word supplies the opcode, the access mode, the dummy byte count, and the chip-select recovery time. A separate per-chip bit selects 32-bit or 24-bit addressing.

Only one read is in flight at a time. The bus master holds its request until it sees a one-cycle acknowledge. Writes never reach the flash. Accesses that are not supported complete at once with an error flag.

Top module: `flash_mmap_rd`

## Requirements
- R1: Segment word bits [31:24] hold the end and bits [23:16] hold the start, in 8 MB units. A read at an address A with start*2^23 <= A < end*2^23 pulls low only that chip's select line (bit i of spi_cs_n for chip i) and completes with bus_err low.
- R2: A segment whose start is greater than or equal to its end matches nothing. A read or write that matches no open segment is acknowledged on the first rising edge after the request, with bus_err high and no chip select pulled low.
- R3: When open segments overlap, the chip with the lowest index is selected.
- R4: The frame begins with the opcode from control bits [23:16], followed by the flash address, most significant bit first. The flash address is the bus address minus start*2^23. All 32 bits are sent when the chip's wide_addr bit is 1. Otherwise only the low 24 bits are sent.
- R5: In mode 1 (control bits [1:0] = 1), D dummy bytes of 0xFF follow the address, where D = {bit 14, bits [7:6]} of the control word. In mode 0, no dummy bytes are sent, whatever that field holds.
- R6: After the header, 32 data bits are sampled on rising SCK edges while MOSI stays high. The first byte received lands in bus_rdata[7:0], the next in [15:8], and so on. Each byte arrives most significant bit first.
- R7: SCK idles low and runs at half the clock rate, with one bit per two clocks. For a frame of B bits issued from idle, bus_ack arrives on the 2B+1-th rising edge counted from the first edge that samples the request.
- R8: A write into an open segment whose chip is in mode 0 or 1 is acknowledged on the first edge with bus_err low, and causes no SPI activity.
- R9: A read or write into a chip in mode 2 or 3 is acknowledged on the first edge with bus_err high, and causes no SPI activity.
- R10: After a read ends, with another read already waiting, the chip select stays high for exactly N+1 clock cycles, where N = 16 - control bits [27:24].
- R11: In reset and directly after it, all chip selects are high and SCK, bus_ack and bus_err are low.
- R12: At most one chip select is low at any time, and bus_ack is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address on the bus |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Error response, valid with bus_ack |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| seg_cfg | input | 32*NCS | Per-chip segment words, chip i in bits [32i+31:32i] |
| ctl_cfg | input | 32*NCS | Per-chip control words |
| wide_addr | input | NCS | Per-chip 32-bit address enable |
| spi_cs_n | output | NCS | Active-low chip selects |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Error and write responses are due on the first rising edge after the request is raised. A read's acknowledge is due 2B+1 edges after the request, where B counts the opcode, address, dummy and data bits. The chip-select recovery is due N+1 cycles after an acknowledge. The bench drives inputs and samples on falling edges, and counts rising edges from the request until the acknowledge is seen. It compares that count with the value it derives from the frame length of that access. It also checks that the acknowledge is gone one falling edge later.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LOW, SQ_HIGH, SQ_GAP} seq_st_e;

  localparam int HDR_W = 96;

  function automatic logic [31:0] swap_bytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/flash_seg_decode.sv
module flash_seg_decode #(
  parameter int NCS  = 2,
  parameter int SELW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic [31:0]       addr,
  input  logic [32*NCS-1:0] seg_cfg,
  output logic              hit,
  output logic [SELW-1:0]   sel,
  output logic [NCS-1:0]    sel_oh,
  output logic [31:0]       offset
);
  logic [NCS-1:0] win;
  logic [7:0]     starts [NCS];
  logic [7:0]     start_sel;
  logic [16*NCS-1:0] low_unused;

  for (genvar i = 0; i < NCS; i++) begin : g_win
    logic [7:0] st_u;
    logic [7:0] en_u;
    assign st_u      = seg_cfg[32*i+16 +: 8];
    assign en_u      = seg_cfg[32*i+24 +: 8];
    assign starts[i] = st_u;
    assign win[i]    = (st_u < en_u) &&
                       ({1'b0, st_u} <= addr[31:23]) &&
                       (addr[31:23] < {1'b0, en_u});
    assign low_unused[16*i +: 16] = seg_cfg[32*i +: 16];
  end

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NCS - 1; i >= 0; i--) begin
      if (win[i]) begin
        hit = 1'b1;
        sel = SELW'(i);
      end
    end
    sel_oh = '0;
    if (hit) sel_oh[sel] = 1'b1;
  end

  assign start_sel = starts[sel];
  assign offset    = {addr[31:23] - {1'b0, start_sel}, addr[22:0]};
endmodule

// File: rtl/flash_spi_seq.sv
module flash_spi_seq
  import flash_rd_pkg::*;
#(
  parameter int NCS = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [NCS-1:0] cs_oh,
  input  logic [7:0]     opcode,
  input  logic [31:0]    faddr,
  input  logic           wide,
  input  logic [2:0]     ndummy,
  input  logic [3:0]     inact,
  input  logic           miso,
  output logic           busy,
  output logic           done,
  output logic [31:0]    data,
  output logic [NCS-1:0] cs_n,
  output logic           sck,
  output logic           mosi
);
  seq_st_e          st;
  logic [HDR_W-1:0] shreg;
  logic [6:0]       cnt;
  logic [6:0]       last;
  logic [3:0]       gap;
  logic [3:0]       gap_init;
  logic [31:0]      rx;
  logic [6:0]       last_c;
  logic [HDR_W-1:0] hdr_c;

  assign last_c = (wide ? 7'd71 : 7'd63) + {1'b0, ndummy, 3'b000};
  assign hdr_c  = wide ? {opcode, faddr, {56{1'b1}}}
                       : {opcode, faddr[23:0], {64{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      cs_n     <= '1;
      sck      <= 1'b0;
      shreg    <= '1;
      cnt      <= '0;
      last     <= '0;
      gap      <= '0;
      gap_init <= '0;
      rx       <= '0;
      done     <= 1'b0;
      data     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start) begin
            cs_n     <= ~cs_oh;
            shreg    <= hdr_c;
            cnt      <= '0;
            last     <= last_c;
            gap_init <= 4'd15 - inact;
            st       <= SQ_LOW;
          end
        end
        SQ_LOW: begin
          sck <= 1'b1;
          rx  <= {rx[30:0], miso};
          st  <= SQ_HIGH;
        end
        SQ_HIGH: begin
          sck <= 1'b0;
          if (cnt == last) begin
            cs_n <= '1;
            done <= 1'b1;
            data <= swap_bytes(rx);
            gap  <= gap_init;
            st   <= SQ_GAP;
          end else begin
            cnt   <= cnt + 7'd1;
            shreg <= {shreg[HDR_W-2:0], 1'b1};
            st    <= SQ_LOW;
          end
        end
        default: begin
          if (gap == 4'd0) st <= SQ_IDLE;
          else             gap <= gap - 4'd1;
        end
      endcase
    end
  end

  assign busy = (st != SQ_IDLE);
  assign mosi = shreg[HDR_W-1];
endmodule

// File: rtl/flash_mmap_rd.sv
module flash_mmap_rd #(
  parameter int NCS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [31:0]       bus_addr,
  output logic              bus_ack,
  output logic              bus_err,
  output logic [31:0]       bus_rdata,
  input  logic [32*NCS-1:0] seg_cfg,
  input  logic [32*NCS-1:0] ctl_cfg,
  input  logic [NCS-1:0]    wide_addr,
  output logic [NCS-1:0]    spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int SELW = (NCS > 1) ? $clog2(NCS) : 1;

  logic            hit;
  logic [SELW-1:0] sel;
  logic [NCS-1:0]  sel_oh;
  logic [31:0]     offset;
  logic [31:0]     ctl_arr [NCS];
  logic [31:0]     ctl_sel;
  logic [1:0]      mode;
  logic [2:0]      dcount;
  logic [2:0]      ndummy;
  logic            mode_ok;
  logic            accept;
  logic            start;
  logic            busy;
  logic            done;
  logic [31:0]     seq_data;
  logic            imm_ack;
  logic            imm_err;
  logic [11:0]     ctl_unused;

  flash_seg_decode #(.NCS(NCS), .SELW(SELW)) u_dec (
    .addr    (bus_addr),
    .seg_cfg (seg_cfg),
    .hit     (hit),
    .sel     (sel),
    .sel_oh  (sel_oh),
    .offset  (offset)
  );

  for (genvar i = 0; i < NCS; i++) begin : g_ctl
    assign ctl_arr[i] = ctl_cfg[32*i +: 32];
  end

  assign ctl_sel    = ctl_arr[sel];
  assign mode       = ctl_sel[1:0];
  assign dcount     = {ctl_sel[14], ctl_sel[7:6]};
  assign ndummy     = (mode == 2'd1) ? dcount : 3'd0;
  assign ctl_unused = {ctl_sel[31:28], ctl_sel[15], ctl_sel[13:8], ctl_sel[5]};

  assign mode_ok = hit && !mode[1];
  assign accept  = bus_req && !busy && !bus_ack;
  assign start   = accept && !bus_we && mode_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      imm_ack <= 1'b0;
      imm_err <= 1'b0;
    end else begin
      imm_ack <= accept && !start;
      imm_err <= accept && !start && !mode_ok;
    end
  end

  flash_spi_seq #(.NCS(NCS)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .cs_oh  (sel_oh),
    .opcode (ctl_sel[23:16]),
    .faddr  (offset),
    .wide   (wide_addr[sel]),
    .ndummy (ndummy),
    .inact  (ctl_sel[27:24]),
    .miso   (spi_miso),
    .busy   (busy),
    .done   (done),
    .data   (seq_data),
    .cs_n   (spi_cs_n),
    .sck    (spi_sck),
    .mosi   (spi_mosi)
  );

  assign bus_ack   = imm_ack | done;
  assign bus_err   = imm_err;
  assign bus_rdata = done ? seq_data : 32'd0;
endmodule

// File: rtl/flash_mmap_rd_chk.sv
module flash_mmap_rd_chk #(
  parameter int NCS = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_ack,
  input logic           bus_err,
  input logic [NCS-1:0] spi_cs_n,
  input logic           spi_sck
);
  // R12
  one_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~spi_cs_n));

  // R12
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  // R2
  err_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_ack);

  // R7
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (&spi_cs_n) |-> !spi_sck);

  // R6
  frame_end_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(&spi_cs_n) |-> (bus_ack && !bus_err));
endmodule

bind flash_mmap_rd flash_mmap_rd_chk #(.NCS(NCS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_ack  (bus_ack),
  .bus_err  (bus_err),
  .spi_cs_n (spi_cs_n),
  .spi_sck  (spi_sck)
);

// File: tb/sim_flash_mmap_rd.sv
module sim_flash_mmap_rd;
  localparam int NCS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic              bus_req = 1'b0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_addr = '0;
  logic              bus_ack;
  logic              bus_err;
  logic [31:0]       bus_rdata;
  logic [32*NCS-1:0] seg_cfg = '0;
  logic [32*NCS-1:0] ctl_cfg = '0;
  logic [NCS-1:0]    wide_addr = '0;
  logic [NCS-1:0]    spi_cs_n;
  logic              spi_sck;
  logic              spi_mosi;
  logic              spi_miso = 1'b0;

  flash_mmap_rd #(.NCS(NCS)) u0 (.*);

  int checks = 0;
  int fails  = 0;

  // flash model state
  logic [127:0] cap;
  int           nbits;
  logic [1:0]   cs_seen;
  bit           cs_act;
  int           exp_tx;
  logic [31:0]  resp;
  int           idx;

  always @(posedge spi_sck) begin
    if (spi_cs_n != 2'b11) begin
      cap     = {cap[126:0], spi_mosi};
      nbits   = nbits + 1;
      cs_seen = cs_seen | ~spi_cs_n;
    end
  end

  always @(negedge spi_sck) begin
    idx = nbits - exp_tx;
    if (idx >= 0 && idx < 32) spi_miso = resp[(idx / 8) * 8 + 7 - (idx % 8)];
  end

  always @(negedge clk) if (spi_cs_n != 2'b11) cs_act = 1'b1;

  task automatic chk(input bit ok, input string r, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctl(input logic [7:0] op, input logic [1:0] md,
                                         input logic [2:0] dm, input logic [3:0] ia,
                                         input logic [31:0] junk);
    return (junk & 32'hF000_BF3C) | ({28'd0, ia} << 24) | ({24'd0, op} << 16) |
           ({31'd0, dm[2]} << 14) | ({30'd0, dm[1:0]} << 6) | {30'd0, md};
  endfunction

  function automatic logic [127:0] exp_stream(input logic [7:0] op, input logic [31:0] fa,
                                              input bit w, input int nd);
    logic [127:0] s;
    s = '0;
    s = {s[119:0], op};
    if (w) s = {s[95:0], fa};
    else   s = {s[103:0], fa[23:0]};
    for (int k = 0; k < nd; k++) s = {s[119:0], 8'hFF};
    s = {s[95:0], 32'hFFFF_FFFF};
    return s;
  endfunction

  task automatic set_seg(input int c, input logic [7:0] st, input logic [7:0] en);
    seg_cfg[c*32 +: 32] = {en, st, 16'h0000};
  endtask

  task automatic txn(input bit we, input logic [31:0] a, output int cyc,
                     output logic e, output logic [31:0] d);
    nbits = 0; cap = '0; cs_seen = '0; cs_act = 1'b0;
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; cyc = 0;
    do begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end while (!bus_ack && cyc < 2000);
    e = bus_err; d = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_check(input int c, input logic [31:0] a, input logic [7:0] op,
                          input logic [1:0] md, input logic [2:0] dm, input bit w,
                          input logic [3:0] ia);
    int cyc; logic e; logic [31:0] d; logic [31:0] fa; int nd;
    ctl_cfg[c*32 +: 32] = mk_ctl(op, md, dm, ia, $urandom);
    wide_addr[c] = w;
    nd = (md == 2'd1) ? int'(dm) : 0;
    exp_tx = 8 + (w ? 32 : 24) + 8 * nd;
    resp = $urandom;
    fa = a - {seg_cfg[c*32+16 +: 8], 23'd0};
    if (!w) fa = fa & 32'h00FF_FFFF;
    txn(1'b0, a, cyc, e, d);
    chk(e == 1'b0, "R1 read error flag", e, 0);
    chk(cs_seen == (2'b01 << c), "R1 chip select", cs_seen, 2'b01 << c);
    chk(nbits == exp_tx + 32, "R5 frame bit count", nbits, exp_tx + 32);
    chk(cap == exp_stream(op, fa, w, nd), "R4 opcode/address/dummy stream", cap,
        exp_stream(op, fa, w, nd));
    chk(d == resp, "R6 read data", d, resp);
    chk(cyc == 2 * (exp_tx + 32) + 1, "R7 ack latency", cyc, 2 * (exp_tx + 32) + 1);
    @(negedge clk);
    chk(!bus_ack, "R12 ack single cycle", bus_ack, 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic imm_check(input bit we, input logic [31:0] a, input bit exp_e,
                           input string r);
    int cyc; logic e; logic [31:0] d;
    txn(we, a, cyc, e, d);
    chk(cyc == 1, r, cyc, 1);
    chk(e == exp_e, r, e, exp_e);
    chk(cs_act == 1'b0, r, cs_act, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic gap_check(input logic [3:0] ia);
    int cyc; logic e; logic [31:0] d; int hi; int n;
    ctl_cfg[31:0] = mk_ctl(8'h0B, 2'd1, 3'd1, ia, 32'd0);
    wide_addr[0] = 1'b0;
    exp_tx = 8 + 24 + 8;
    resp = $urandom;
    txn(1'b0, 32'h0100_0040, cyc, e, d);
    nbits = 0;
    bus_req = 1'b1; bus_addr = 32'h0100_0080;
    hi = 1;
    forever begin
      @(negedge clk);
      if (spi_cs_n == 2'b11 && hi < 100) hi++;
      else break;
    end
    n = 16 - int'(ia);
    chk(hi == n + 1, "R10 chip select recovery", hi, n + 1);
    cyc = 0;
    while (!bus_ack && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(bus_rdata == resp, "R10 second read data", bus_rdata, resp);
    bus_req = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R7 watchdog expired: actual 150000 cycles expected fewer");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    exp_tx = 1000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(spi_cs_n == 2'b11 && !spi_sck && !bus_ack && !bus_err, "R11 reset state",
        {spi_cs_n, spi_sck, bus_ack, bus_err}, 5'b11000);
    rst = 1'b0;
    @(negedge clk);
    chk(spi_cs_n == 2'b11 && !spi_sck && !bus_ack && !bus_err, "R11 after reset",
        {spi_cs_n, spi_sck, bus_ack, bus_err}, 5'b11000);

    set_seg(0, 8'd2, 8'd4);
    set_seg(1, 8'd4, 8'd8);

    // directed corners
    rd_check(0, 32'h0100_0004, 8'h03, 2'd0, 3'd7, 1'b0, 4'd12); // R5 mode 0 ignores dummy
    rd_check(0, 32'h0180_0010, 8'h0B, 2'd1, 3'd7, 1'b1, 4'd0);  // R5 max dummy
    rd_check(1, 32'h03AB_CDE0, 8'h13, 2'd0, 3'd0, 1'b0, 4'd15); // R4 24-bit truncation
    rd_check(1, 32'h03AB_CDE0, 8'h13, 2'd0, 3'd0, 1'b1, 4'd15); // R4 full 32 bits
    rd_check(1, 32'h03FF_FFFC, 8'h0C, 2'd1, 3'd2, 1'b1, 4'd8);  // R1 last word of window

    // random reads
    for (int t = 0; t < 40; t++) begin
      int c; logic [31:0] base; logic [31:0] span;
      c = int'($urandom % 2);
      base = {seg_cfg[c*32+16 +: 8], 23'd0};
      span = {seg_cfg[c*32+24 +: 8] - seg_cfg[c*32+16 +: 8], 23'd0};
      rd_check(c, base + ($urandom % span), 8'($urandom), 2'($urandom % 2),
               3'($urandom), 1'($urandom), 4'($urandom));
    end

    // R8 writes into read-mode chips are ignored
    ctl_cfg[31:0] = mk_ctl(8'h03, 2'd0, 3'd0, 4'd0, 32'd0);
    imm_check(1'b1, 32'h0100_0000, 1'b0, "R8 write in mode 0");
    ctl_cfg[31:0] = mk_ctl(8'h0B, 2'd1, 3'd3, 4'd0, 32'd0);
    imm_check(1'b1, 32'h01FF_FFF0, 1'b0, "R8 write in mode 1");

    // R9 write/user modes
    ctl_cfg[63:32] = mk_ctl(8'h02, 2'd2, 3'd0, 4'd0, 32'd0);
    imm_check(1'b0, 32'h0200_0000, 1'b1, "R9 read in mode 2");
    ctl_cfg[63:32] = mk_ctl(8'h02, 2'd3, 3'd0, 4'd0, 32'd0);
    imm_check(1'b1, 32'h0300_0000, 1'b1, "R9 write in mode 3");
    ctl_cfg[63:32] = mk_ctl(8'h03, 2'd0, 3'd0, 4'd0, 32'd0);

    // R2 unmatched and closed segments
    imm_check(1'b0, 32'h0000_0010, 1'b1, "R2 address below all windows");
    imm_check(1'b0, 32'h0400_0000, 1'b1, "R2 address at end of window");
    set_seg(0, 8'd3, 8'd3);
    imm_check(1'b0, 32'h0180_0000, 1'b1, "R2 closed segment start==end");
    set_seg(0, 8'd5, 8'd2);
    imm_check(1'b0, 32'h0120_0000, 1'b1, "R2 closed segment start>end");

    // R3 overlapping windows: lowest index wins
    set_seg(0, 8'd2, 8'd6);
    rd_check(0, 32'h0240_0000, 8'h03, 2'd0, 3'd0, 1'b1, 4'd0);

    // R10 chip select recovery
    set_seg(0, 8'd2, 8'd4);
    gap_check(4'd15);
    gap_check(4'd0);
    gap_check(4'd9);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule